// File: doc/BRIEF.md
# Phased Arrival Barrier State Unit

This block keeps a small table of 64-bit barrier words for agents that share a local memory. A single command port takes one request per cycle: set up a barrier for a given number of participants, read a barrier word atomically, or record an arrival with a count. Every request finishes its read-modify-write in the cycle it is accepted. One cycle later the block returns the word as it stood before the request, flagged valid.

A barrier word has three fields. The low 28 bits count the arrivals still outstanding. Bits 31:28 hold a 4-bit phase. The upper 32 bits hold the value the count is reloaded from. An arrival removes its count once for each active lane. When the outstanding count cannot cover that amount, the count is refilled from the reload value, the phase steps down by one, and a one-cycle wake event goes out tagged with the barrier index. Sleeping agents use that event to check the barrier again.

Four field outputs decode the returned word without a clock: phase, phase parity, outstanding count and reload value.

Top module: `phase_barrier_unit`

## Requirements
- R1: Word layout: bits 27:0 outstanding count, bits 31:28 phase, bits 63:32 reload value. The field outputs decode the returned word as follows: phase = bits 31:28, parity = bit 28, outstanding = low 32 bits AND 0x0FFFFFFF, reload = bits 63:32.
- R2: Setup (op code 01) with participant number P writes (P-1) masked to 28 bits into both the outstanding count and the reload value, and clears the phase. P=0 therefore gives 0x0FFFFFFF.
- R3: After setup with P, the phase changes on exactly the P-th unit of arrival.
- R4: An arrival (op code 10) subtracts count × (number of ones in the lane mask) from the outstanding count. An empty lane mask leaves the word unchanged.
- R5: When the amount exceeds the outstanding count, the count is reloaded from bits 27:0 of the reload value, and the phase is decremented modulo 16, so 0 steps to 15.
- R6: Each phase change raises wake_valid for exactly one cycle, together with the response, with wake_idx equal to the barrier index. There is no wake at any other time.
- R7: Every request returns the full word as it was before the request. Poll (op code 00, and op code 11 treated alike) does not modify the word.
- R8: rsp_valid is high in the cycle after each accepted request and low after an idle cycle. Back-to-back requests to the same barrier see each other's updates.
- R9: An arrival far larger than the outstanding count steps the phase only once and reloads the count. No remainder carries over.
- R10: An index at or above ENTRIES raises rsp_err, returns an all-zero word, and changes no barrier.
- R11: After reset every barrier word is zero and no response or wake is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 poll, 01 setup, 10 arrive, 11 poll |
| req_idx | input | IDX_W | Barrier index |
| req_arg | input | ARG_W | Participant number (setup) or per-lane count (arrive) |
| req_lanes | input | LANES | Active-lane mask for arrive |
| rsp_valid | output | 1 | Response valid |
| rsp_state | output | 64 | Word before the request |
| rsp_err | output | 1 | Index was out of range |
| wake_valid | output | 1 | Phase changed on this response |
| wake_idx | output | IDX_W | Barrier whose phase changed |
| fld_phase | output | 4 | Phase of rsp_state |
| fld_parity | output | 1 | Phase parity of rsp_state |
| fld_pending | output | 32 | Outstanding count of rsp_state |
| fld_init | output | 32 | Reload value of rsp_state |

## Verification
The bench aims at several boundary cases:
- An off-by-one in the minus-one setup encoding would move the phase change to the (P-1)-th or (P+1)-th arrival.
- Using a plain count instead of count × active lanes would leave the outstanding value wrong after a multi-lane arrival.
- An oversized arrival that carries its remainder, or that steps the phase twice, would show a wrong count or phase on the next poll.
- A phase that saturates at zero would never return to 15 during the sixteen-step wrap test.
- A wake with a wrong index or wrong timing is caught because the wake outputs are compared every clock.
- An out-of-range request that leaks into some entry shows up when every barrier is polled afterwards.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
   localparam int PEND_W  = 28;
   localparam int PHASE_W = 4;
   localparam int INIT_W  = 32;
   localparam int WORD_W  = PEND_W + PHASE_W + INIT_W;

   typedef enum logic [1:0] {
      OP_POLL   = 2'b00,
      OP_SETUP  = 2'b01,
      OP_ARRIVE = 2'b10,
      OP_PEEK   = 2'b11
   } pbu_op_e;

   typedef struct packed {
      logic [INIT_W-1:0]  reload;
      logic [PHASE_W-1:0] phase;
      logic [PEND_W-1:0]  pending;
   } pbu_word_t;
endpackage

// File: rtl/pbu_lane_scale.sv
module pbu_lane_scale #(
   parameter int LANES = 4,
   parameter int ARG_W = 32,
   localparam int CNT_W = $clog2(LANES + 1),
   localparam int DEC_W = ARG_W + CNT_W
) (
   input  logic [ARG_W-1:0] count,
   input  logic [LANES-1:0] lanes,
   output logic [DEC_W-1:0] amount
);
   generate
      if (LANES == 1) begin : g_single
         assign amount = lanes[0] ? DEC_W'(count) : '0;
      end else begin : g_multi
         logic [CNT_W-1:0] active;
         always_comb begin
            active = '0;
            for (int i = 0; i < LANES; i++) active = active + CNT_W'(lanes[i]);
         end
         assign amount = DEC_W'(count) * DEC_W'(active);
      end
   endgenerate
endmodule

// File: rtl/pbu_next.sv
module pbu_next
   import pbu_pkg::*;
#(
   parameter int DEC_W = 35
) (
   input  pbu_word_t         cur,
   input  logic [1:0]        op,
   input  logic [PEND_W-1:0] parts,
   input  logic [DEC_W-1:0]  amount,
   output pbu_word_t         nxt,
   output logic              rolled
);
   logic [PEND_W-1:0] setup_cnt;
   assign setup_cnt = parts - PEND_W'(1);

   always_comb begin
      nxt    = cur;
      rolled = 1'b0;
      case (pbu_op_e'(op))
         OP_SETUP: begin
            nxt.pending = setup_cnt;
            nxt.reload  = INIT_W'(setup_cnt);
            nxt.phase   = '0;
         end
         OP_ARRIVE: begin
            if (amount > DEC_W'(cur.pending)) begin
               nxt.pending = cur.reload[PEND_W-1:0];
               nxt.phase   = cur.phase - PHASE_W'(1);
               rolled      = 1'b1;
            end else begin
               nxt.pending = cur.pending - PEND_W'(amount);
            end
         end
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/pbu_store.sv
module pbu_store
   import pbu_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  pbu_word_t        wr_word,
   output pbu_word_t        rd_word
);
   pbu_word_t slots [ENTRIES];

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            slots[e] <= '0;
            else if (wr_en && idx == IDX_W'(e))    slots[e] <= wr_word;
         end
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (idx == IDX_W'(e)) rd_word = slots[e];
   end
endmodule

// File: rtl/pbu_fields.sv
module pbu_fields
   import pbu_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output logic [3:0]        phase,
   output logic              parity,
   output logic [31:0]       pending,
   output logic [31:0]       reload
);
   assign phase   = word[31:28];
   assign parity  = word[28];
   assign pending = word[31:0] & 32'h0FFF_FFFF;
   assign reload  = word[63:32];
endmodule

// File: rtl/phase_barrier_unit.sv
module phase_barrier_unit
   import pbu_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 4,
   parameter int LANES   = 4,
   parameter int ARG_W   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic [IDX_W-1:0] req_idx,
   input  logic [ARG_W-1:0] req_arg,
   input  logic [LANES-1:0] req_lanes,
   output logic             rsp_valid,
   output logic [63:0]      rsp_state,
   output logic             rsp_err,
   output logic             wake_valid,
   output logic [IDX_W-1:0] wake_idx,
   output logic [3:0]       fld_phase,
   output logic             fld_parity,
   output logic [31:0]      fld_pending,
   output logic [31:0]      fld_init
);
   localparam int DEC_W = ARG_W + $clog2(LANES + 1);

   generate
      if (ENTRIES < 1 || ENTRIES > (1 << IDX_W)) begin : g_bad_depth
         $error("ENTRIES must be in 1..2**IDX_W");
      end
      if (ARG_W < PEND_W) begin : g_bad_arg
         $error("ARG_W must cover the outstanding count field");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
   endgenerate

   logic             in_range;
   logic [DEC_W-1:0] amount;
   pbu_word_t        cur_word, nxt_word;
   logic             rolled, wr_en;

   assign in_range = 32'(req_idx) < ENTRIES;
   assign wr_en    = req_valid && in_range &&
                     (req_op == OP_SETUP || req_op == OP_ARRIVE);

   pbu_lane_scale #(.LANES(LANES), .ARG_W(ARG_W)) u_scale (
      .count(req_arg), .lanes(req_lanes), .amount(amount)
   );

   pbu_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(req_idx),
      .wr_word(nxt_word), .rd_word(cur_word)
   );

   pbu_next #(.DEC_W(DEC_W)) u_next (
      .cur(cur_word), .op(req_op), .parts(req_arg[PEND_W-1:0]),
      .amount(amount), .nxt(nxt_word), .rolled(rolled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_state  <= '0;
         rsp_err    <= 1'b0;
         wake_valid <= 1'b0;
         wake_idx   <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_err    <= req_valid && !in_range;
         rsp_state  <= (req_valid && in_range) ? cur_word : '0;
         wake_valid <= wr_en && rolled;
         wake_idx   <= req_idx;
      end
   end

   pbu_fields u_fields (
      .word(rsp_state), .phase(fld_phase), .parity(fld_parity),
      .pending(fld_pending), .reload(fld_init)
   );
endmodule

// File: rtl/pbu_chk.sv
module pbu_chk #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       req_op,
   input logic [IDX_W-1:0] req_idx,
   input logic             rsp_valid,
   input logic [63:0]      rsp_state,
   input logic             rsp_err,
   input logic             wake_valid,
   input logic [IDX_W-1:0] wake_idx
);
   // R8
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R8
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R6
   wake_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> (rsp_valid && !rsp_err));
   // R6
   wake_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> (wake_idx == $past(req_idx)));
   // R6
   wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_valid && !req_valid) |=> !wake_valid);
   // R10
   range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && 32'(req_idx) >= ENTRIES) |=> (rsp_err && rsp_state == 64'd0));
   // R7
   poll_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_valid && req_op == 2'b00) && req_valid && req_op == 2'b00 &&
       req_idx == $past(req_idx)) |=> $stable(rsp_state));
endmodule

bind phase_barrier_unit pbu_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pbu_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .req_idx(req_idx), .rsp_valid(rsp_valid), .rsp_state(rsp_state),
   .rsp_err(rsp_err), .wake_valid(wake_valid), .wake_idx(wake_idx)
);

// File: tb/phase_barrier_unit_test.sv
module phase_barrier_unit_test;
   localparam int ENTRIES = 8;
   localparam int IDX_W   = 4;
   localparam int LANES   = 4;
   localparam int ARG_W   = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic [IDX_W-1:0] req_idx = '0;
   logic [ARG_W-1:0] req_arg = '0;
   logic [LANES-1:0] req_lanes = '0;
   logic rsp_valid, rsp_err, wake_valid, fld_parity;
   logic [63:0] rsp_state;
   logic [IDX_W-1:0] wake_idx;
   logic [3:0] fld_phase;
   logic [31:0] fld_pending, fld_init;

   int total = 0;
   int bad = 0;
   logic [63:0] model [ENTRIES];

   always #10 clk = ~clk;

   phase_barrier_unit #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .LANES(LANES), .ARG_W(ARG_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_idx(req_idx), .req_arg(req_arg), .req_lanes(req_lanes),
      .rsp_valid(rsp_valid), .rsp_state(rsp_state), .rsp_err(rsp_err),
      .wake_valid(wake_valid), .wake_idx(wake_idx), .fld_phase(fld_phase),
      .fld_parity(fld_parity), .fld_pending(fld_pending), .fld_init(fld_init)
   );

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag, bit ev, bit ee, logic [63:0] es, bit ew, int ewi);
      check(tag, "rsp_valid", 64'(rsp_valid), 64'(ev));
      check(tag, "wake_valid", 64'(wake_valid), 64'(ew));
      if (ev) begin
         check(tag, "rsp_err", 64'(rsp_err), 64'(ee));
         check(tag, "rsp_state", rsp_state, es);
         // R1 field decode
         check(tag, "fld_phase", 64'(fld_phase), 64'(es[31:28]));
         check(tag, "fld_parity", 64'(fld_parity), 64'(es[28]));
         check(tag, "fld_pending", 64'(fld_pending), 64'(es[31:0] & 32'h0FFF_FFFF));
         check(tag, "fld_init", 64'(fld_init), 64'(es[63:32]));
      end
      if (ew) check(tag, "wake_idx", 64'(wake_idx), 64'(ewi));
   endtask

   // reference model: one request, then compare on the next falling edge
   task automatic issue(string tag, int op, int idx, longint arg, int lanes);
      logic [63:0] es;
      bit ee, ew;
      longint pend, ph, rel, amt;
      int n;
      req_valid = 1'b1; req_op = op[1:0]; req_idx = idx[IDX_W-1:0];
      req_arg = arg[ARG_W-1:0]; req_lanes = lanes[LANES-1:0];
      ee = (idx >= ENTRIES); ew = 0;
      es = ee ? 64'd0 : model[idx];
      if (!ee) begin
         pend = longint'(es[27:0]); ph = longint'(es[31:28]); rel = longint'(es[63:32]);
         if (op == 1) begin
            pend = (arg - 1) & 64'h0FFF_FFFF;
            model[idx] = {32'(pend), 4'd0, 28'(pend)};
         end else if (op == 2) begin
            n = $countones(lanes[LANES-1:0]);
            amt = arg * n;
            if (amt > pend) begin
               pend = rel & 64'h0FFF_FFFF;
               ph = (ph + 15) % 16;
               ew = 1;
            end else pend = pend - amt;
            model[idx] = {32'(rel), 4'(ph), 28'(pend)};
         end
      end
      @(negedge clk);
      compare(tag, 1, ee, es, ew, idx);
   endtask

   task automatic idle(string tag);
      req_valid = 1'b0;
      @(negedge clk);
      compare(tag, 0, 0, 64'd0, 0, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < ENTRIES; i++) model[i] = 64'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      idle("R11");
      for (int i = 0; i < ENTRIES; i++) issue("R11", 0, i, 0, 0);
      // R2 setup P=3, then poll
      issue("R2", 1, 0, 3, 0);
      issue("R2", 0, 0, 0, 0);
      // R3 phase change on third unit arrival, R5 phase 0 -> 15, R6 wake
      issue("R3", 2, 0, 1, 1);
      issue("R3", 2, 0, 1, 1);
      issue("R3_R6", 2, 0, 1, 1);
      issue("R5", 0, 0, 0, 0);
      // R4 lane scaling
      issue("R4", 1, 1, 10, 0);
      issue("R4", 2, 1, 2, 4'b1111);
      issue("R4", 2, 1, 7, 4'b0000);
      issue("R4", 0, 1, 0, 0);
      // R9 oversized decrements
      issue("R9", 2, 1, 1, 4'b0011);
      issue("R9", 2, 1, 100, 4'b1111);
      issue("R9", 0, 1, 0, 0);
      // R2 P=0 masks to 0x0FFFFFFF
      issue("R2", 1, 2, 0, 0);
      issue("R2", 0, 2, 0, 0);
      // R7 op 11 acts as poll; arrive returns prior word
      issue("R7", 3, 2, 0, 0);
      issue("R7", 2, 2, 5, 4'b0101);
      issue("R7", 3, 2, 0, 0);
      // R10 out-of-range requests
      issue("R10", 1, 9, 4, 0);
      issue("R10", 2, 15, 1, 4'b1111);
      idle("R8");
      for (int i = 0; i < ENTRIES; i++) issue("R10", 0, i, 0, 0);
      // R5 full sixteen-step phase wrap with P=1
      issue("R5", 1, 3, 1, 0);
      for (int k = 0; k < 16; k++) issue("R5", 2, 3, 1, 4'b1000);
      issue("R5", 0, 3, 0, 0);
      // R8 back-to-back on one barrier, then idle
      issue("R8", 1, 4, 2, 0);
      issue("R8", 2, 4, 1, 1);
      issue("R8", 2, 4, 1, 1);
      issue("R8", 0, 4, 0, 0);
      idle("R8");
      idle("R6");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule